// File: doc/BRIEF.md
# Dual-CPU System Register Block

A shared control block reached by two processors, each through its own 16-bit register port. The host processor owns the adapter enable, a frame-mode bit, a 3-bit ROM bank select and the DMA address words, and it can raise a command interrupt. The second processor sees its own view of the same state. That view holds the frame-mode bit, a constant "adapter present" flag and a 4-bit interrupt mask. It also has one dedicated clear offset for each interrupt source. Both processors share eight communication words.

The interrupt section collects five sources into pending flags. Four of them arrive as single-cycle request pulses: reset, vertical, horizontal and PWM. The fifth is the host command. From the pending flags the block drives a prioritised level to the second processor. ROM remapping, video timing and PWM generation sit outside the block. It only registers the bank number and the requests.

Nothing the host writes takes effect until the adapter is enabled. A host byte write to offset 1 enables it, and only a reset disables it again. Reads on both ports are combinational. Writes take effect at the clock edge.

Top module: `dual_cpu_sysregs`

## Requirements
- R1: Out of reset `adapter_en` is 0. While it is 0, a host byte write to offset 1 sets it, whatever the data. Every other host write leaves all state unchanged. Only reset clears it.
- R2: With the adapter enabled, the following host writes load `frame_mode`:
  - a host word write to offset 0 loads it from data bit 15;
  - a host byte write to offset 0 loads it from data bit 7.
  
  Neither write changes `adapter_en`. A host read of offset 0 returns `frame_mode` in bit 15 and `adapter_en` in bit 0, with all other bits 0.
- R3: A host word write to offset 4, or a host byte write to offset 5, loads `bank_sel` from data bits [2:0]. A host read of offset 4 returns the bank zero-extended.
- R4: A host word write to offset 2, or a host byte write to offset 3, with data bit 0 set marks the command interrupt pending. With bit 0 clear the write has no effect.
- R5: The communication words sit at word offsets 0x20 to 0x2E. Either processor can word-write them and read them back. If both write the same word in the same cycle, the second processor's value is kept.
- R6: The DMA words sit at offsets 0x08 to 0x0E. Host word writes load them and both ports read them. Second-processor writes do not change them.
- R7: A second-processor read of offset 0 returns `frame_mode` in bit 15, a constant 1 in bit 9 and the mask in bits [3:0], with all other bits 0. The mask loads from data bits [3:0] on a second-processor word write to offset 0 or byte write to offset 1.
- R8: A second-processor write to the following offsets clears one pending source (the byte or the word form at the pair's even or odd offset):

  | Offset | Source cleared |
  |---|---|
  | 0x14 | reset |
  | 0x16 | vertical |
  | 0x18 | horizontal |
  | 0x1A | command |
  | 0x1C | PWM |

  A request that arrives in the same cycle as the clear of its own source leaves that source pending.
- R9: `irq_level` is 14 for reset (never masked), 12 for vertical (mask bit 3), 10 for horizontal (mask bit 2), 8 for command (mask bit 1), 6 for PWM (mask bit 0) and 0 when nothing enabled is pending. The highest-priority enabled source wins.
- R10: Second-processor reads of offsets outside 0x00–0x01, 0x08–0x0F and 0x20–0x2F return 0. Host reads of offsets other than 0, 4, 0x08–0x0F and 0x20–0x2F return 0.
- R11: A request pulse on `vres_req`, `vint_req`, `hint_req` or `pwm_req` marks its source pending at that clock edge. The resulting level is visible right after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_byte | input | 1 | Host access is a byte (1) or a word (0) |
| h_addr | input | 6 | Host byte offset; even offset is the high byte |
| h_wdata | input | 16 | Host write data; byte writes use bits [7:0] |
| h_rdata | output | 16 | Host read data for word at h_addr |
| s_wr | input | 1 | Second-processor write strobe |
| s_byte | input | 1 | Second-processor access is a byte (1) or a word (0) |
| s_addr | input | 8 | Second-processor byte offset |
| s_wdata | input | 16 | Second-processor write data |
| s_rdata | output | 16 | Second-processor read data |
| vres_req | input | 1 | Reset interrupt request pulse |
| vint_req | input | 1 | Vertical interrupt request pulse |
| hint_req | input | 1 | Horizontal interrupt request pulse |
| pwm_req | input | 1 | PWM interrupt request pulse |
| adapter_en | output | 1 | Adapter enable |
| frame_mode | output | 1 | Frame-mode bit |
| bank_sel | output | 3 | ROM bank select |
| irq_level | output | 4 | Prioritised interrupt level to the second processor |

## Verification
Two functions can land in the same cycle, and the bench drives both ports in one cycle to force each case:
- A raise and a clear of the same interrupt source can coincide. In one case the host raises the command interrupt while the second processor writes the command clear offset. In the other, the reset request pulses during the reset clear write. The pending source must survive, and the bench judges this from `irq_level` after the edge.
- Both ports can write the same communication word at once. The word read back through both ports must hold the second processor's value.

The interrupt priority is swept over all 32 pending patterns and all 16 masks.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int NSRC   = 5;
  localparam int MASK_W = 4;
  localparam int LVL_W  = 4;

  // pending-vector bit positions (priority: higher index wins)
  localparam int SRC_PWM  = 0;
  localparam int SRC_CMD  = 1;
  localparam int SRC_HINT = 2;
  localparam int SRC_VINT = 3;
  localparam int SRC_VRES = 4;

  // level for a pending set under a mask; the reset source ignores the mask
  function automatic logic [LVL_W-1:0] irq_level_f(input logic [NSRC-1:0] pend,
                                                   input logic [MASK_W-1:0] mask);
    logic [NSRC-1:0] live;
    live = {pend[SRC_VRES], pend[SRC_VINT:SRC_PWM] & mask};
    if (live[SRC_VRES])      return 4'd14;
    else if (live[SRC_VINT]) return 4'd12;
    else if (live[SRC_HINT]) return 4'd10;
    else if (live[SRC_CMD])  return 4'd8;
    else if (live[SRC_PWM])  return 4'd6;
    else                     return 4'd0;
  endfunction
endpackage

// File: rtl/dcs_word_bank.sv
module dcs_word_bank #(
  parameter int N  = 8,
  parameter int W  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [IW-1:0] a_idx,
  input  logic [W-1:0]  a_d,
  input  logic          b_we,
  input  logic [IW-1:0] b_idx,
  input  logic [W-1:0]  b_d,
  input  logic [IW-1:0] ra_idx,
  output logic [W-1:0]  ra_q,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  rb_q
);
  logic [W-1:0] mem [N];

  // port b takes precedence when both hit one word
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n)                          mem[i] <= '0;
      else if (b_we && b_idx == IW'(i))    mem[i] <= b_d;
      else if (a_we && a_idx == IW'(i))    mem[i] <= a_d;
    end
  end

  assign ra_q = mem[ra_idx];
  assign rb_q = mem[rb_idx];
endmodule

// File: rtl/dcs_irq_ctrl.sv
module dcs_irq_ctrl
  import dcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   set_i,
  input  logic [NSRC-1:0]   clr_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [NSRC-1:0]   pend_o,
  output logic [LVL_W-1:0]  level_o
);
  // a request in the same cycle as its clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end

  assign level_o = irq_level_f(pend_o, mask_i);
endmodule

// File: rtl/dual_cpu_sysregs.sv
module dual_cpu_sysregs
  import dcs_pkg::*;
#(
  parameter int DW         = 16,
  parameter int COMM_WORDS = 8,
  parameter int DMA_WORDS  = 4,
  parameter int BANK_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic              h_byte,
  input  logic [5:0]        h_addr,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  input  logic              s_wr,
  input  logic              s_byte,
  input  logic [7:0]        s_addr,
  input  logic [DW-1:0]     s_wdata,
  output logic [DW-1:0]     s_rdata,
  input  logic              vres_req,
  input  logic              vint_req,
  input  logic              hint_req,
  input  logic              pwm_req,
  output logic              adapter_en,
  output logic              frame_mode,
  output logic [BANK_W-1:0] bank_sel,
  output logic [LVL_W-1:0]  irq_level
);
  localparam int CIW = $clog2(COMM_WORDS);
  localparam int DIW = $clog2(DMA_WORDS);

  logic [MASK_W-1:0] irq_mask;

  // ---------------- host write decode (named events) ----------------
  logic host_live, host_en_set, host_lane_ok;
  logic host_fm_we, host_fm_val, host_bank_we, host_cmd_raise;
  logic host_comm_we, host_dma_we;

  assign host_live      = h_wr & adapter_en;
  assign host_en_set    = h_wr & h_byte & (h_addr == 6'd1) & ~adapter_en;
  assign host_lane_ok   = h_byte ? h_addr[0] : 1'b1;
  assign host_fm_we     = host_live & (h_addr[5:1] == 5'd0) & ~(h_byte & h_addr[0]);
  assign host_fm_val    = h_byte ? h_wdata[7] : h_wdata[DW-1];
  assign host_cmd_raise = host_live & (h_addr[5:1] == 5'd1) & host_lane_ok & h_wdata[0];
  assign host_bank_we   = host_live & (h_addr[5:1] == 5'd2) & host_lane_ok;
  assign host_comm_we   = host_live & ~h_byte & (h_addr[5:4] == 2'b10);
  assign host_dma_we    = host_live & ~h_byte & (h_addr[5:3] == 3'b001);

  // ---------------- second-CPU write decode ----------------
  logic            sub_comm_we, sub_mask_we;
  logic [NSRC-1:0] sub_clr;

  assign sub_comm_we = s_wr & ~s_byte & (s_addr[7:6] == 2'b00) & (s_addr[5:4] == 2'b10);
  assign sub_mask_we = s_wr & (s_addr[7:1] == 7'd0) & (~s_byte | s_addr[0]);

  // clear offsets: PWM at pair 0x0E (0x1C) descending to reset at pair 0x0A (0x14)
  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign sub_clr[i] = s_wr & (s_addr[7:1] == 7'(14 - i));
  end

  // ---------------- control registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adapter_en <= 1'b0;
      frame_mode <= 1'b0;
      bank_sel   <= '0;
      irq_mask   <= '0;
    end else begin
      if (host_en_set)  adapter_en <= 1'b1;
      if (host_fm_we)   frame_mode <= host_fm_val;
      if (host_bank_we) bank_sel   <= h_wdata[BANK_W-1:0];
      if (sub_mask_we)  irq_mask   <= s_wdata[MASK_W-1:0];
    end
  end

  // ---------------- shared storage ----------------
  logic [DW-1:0] comm_h_q, comm_s_q, dma_h_q, dma_s_q;

  dcs_word_bank #(.N(COMM_WORDS), .W(DW)) u_comm (
    .clk(clk), .rst_n(rst_n),
    .a_we(host_comm_we), .a_idx(h_addr[CIW:1]), .a_d(h_wdata),
    .b_we(sub_comm_we),  .b_idx(s_addr[CIW:1]), .b_d(s_wdata),
    .ra_idx(h_addr[CIW:1]), .ra_q(comm_h_q),
    .rb_idx(s_addr[CIW:1]), .rb_q(comm_s_q)
  );

  dcs_word_bank #(.N(DMA_WORDS), .W(DW)) u_dma (
    .clk(clk), .rst_n(rst_n),
    .a_we(host_dma_we), .a_idx(h_addr[DIW:1]), .a_d(h_wdata),
    .b_we(1'b0), .b_idx('0), .b_d('0),
    .ra_idx(h_addr[DIW:1]), .ra_q(dma_h_q),
    .rb_idx(s_addr[DIW:1]), .rb_q(dma_s_q)
  );

  // ---------------- interrupts ----------------
  logic [NSRC-1:0] irq_set, irq_pend;
  assign irq_set = {vres_req, vint_req, hint_req, host_cmd_raise, pwm_req};

  dcs_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_i(irq_set), .clr_i(sub_clr), .mask_i(irq_mask),
    .pend_o(irq_pend), .level_o(irq_level)
  );

  // ---------------- read views ----------------
  always_comb begin
    h_rdata = '0;
    if (h_addr[5:1] == 5'd0)         h_rdata = {frame_mode, {(DW-2){1'b0}}, adapter_en};
    else if (h_addr[5:1] == 5'd2)    h_rdata = DW'(bank_sel);
    else if (h_addr[5:3] == 3'b001)  h_rdata = dma_h_q;
    else if (h_addr[5:4] == 2'b10)   h_rdata = comm_h_q;
  end

  always_comb begin
    s_rdata = '0;
    if (s_addr[7:6] == 2'b00) begin
      if (s_addr[5:1] == 5'd0)
        s_rdata = {frame_mode, 5'd0, 1'b1, 5'd0, irq_mask};
      else if (s_addr[5:3] == 3'b001) s_rdata = dma_s_q;
      else if (s_addr[5:4] == 2'b10)  s_rdata = comm_s_q;
    end
  end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       h_wr,
  input logic       h_byte,
  input logic [5:0] h_addr,
  input logic       s_wr,
  input logic [7:0] s_addr,
  input logic [15:0] s_rdata,
  input logic       vres_req,
  input logic       adapter_en,
  input logic [2:0] bank_sel,
  input logic [3:0] irq_level,
  input logic       host_cmd_raise,
  input logic [4:0] sub_clr
);
  // R1: enable only rises after a host byte write to offset 1
  a_r1_enable_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adapter_en) |-> $past(h_wr && h_byte && h_addr == 6'd1));

  // R1: enable never drops outside reset
  a_r1_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    adapter_en |=> adapter_en);

  // R1: bank frozen while disabled
  a_r1_bank_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !adapter_en |=> $stable(bank_sel));

  // R4: host raise event needs the adapter enabled
  a_r4_raise_gated: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_raise |-> adapter_en);

  // R9: level is one of the defined codes
  a_r9_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == 4'd0 || irq_level == 4'd6 || irq_level == 4'd8 ||
    irq_level == 4'd10 || irq_level == 4'd12 || irq_level == 4'd14);

  // R11: reset request yields top level next cycle
  a_r11_vres_level: assert property (@(posedge clk) disable iff (!rst_n)
    vres_req |=> irq_level == 4'd14);

  // R8: clearing reset with no new request drops the top level
  a_r8_vres_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_clr[4] && !vres_req) |=> irq_level != 4'd14);

  // R8: at most one clear decoded per access
  a_r8_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sub_clr));

  // R8: clear events only from second-CPU writes
  a_r8_clear_src: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_clr != 5'd0) |-> s_wr);

  // R10: offsets at or above 0x40 read as zero
  a_r10_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (s_addr[7:6] != 2'b00) |-> s_rdata == 16'd0);
endmodule

bind dual_cpu_sysregs dcs_checker u_dcs_checker (
  .clk(clk), .rst_n(rst_n),
  .h_wr(h_wr), .h_byte(h_byte), .h_addr(h_addr),
  .s_wr(s_wr), .s_addr(s_addr), .s_rdata(s_rdata),
  .vres_req(vres_req), .adapter_en(adapter_en), .bank_sel(bank_sel),
  .irq_level(irq_level), .host_cmd_raise(host_cmd_raise), .sub_clr(sub_clr)
);

// File: tb/dual_cpu_sysregs_tb.sv
`timescale 1ns/1ps
module dual_cpu_sysregs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_wr = 0, h_byte = 0, s_wr = 0, s_byte = 0;
  logic [5:0] h_addr = '0;
  logic [7:0] s_addr = '0;
  logic [15:0] h_wdata = '0, s_wdata = '0, h_rdata, s_rdata;
  logic vres_req = 0, vint_req = 0, hint_req = 0, pwm_req = 0;
  logic adapter_en, frame_mode;
  logic [2:0] bank_sel;
  logic [3:0] irq_level;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side model
  logic        m_fm;
  logic [3:0]  m_mask;
  logic [15:0] m_comm [8];
  logic [15:0] m_dma [4];

  always #10 clk = ~clk;  // 50 MHz

  dual_cpu_sysregs u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_wr(h_wr), .h_byte(h_byte), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .s_wr(s_wr), .s_byte(s_byte), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .vres_req(vres_req), .vint_req(vint_req), .hint_req(hint_req), .pwm_req(pwm_req),
    .adapter_en(adapter_en), .frame_mode(frame_mode), .bank_sel(bank_sel),
    .irq_level(irq_level)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edge_done();
    @(posedge clk); #1;
    h_wr = 0; s_wr = 0; vres_req = 0; vint_req = 0; hint_req = 0; pwm_req = 0;
  endtask

  task automatic hw(input logic b, input logic [5:0] a, input logic [15:0] d);
    h_wr = 1; h_byte = b; h_addr = a; h_wdata = d; edge_done();
  endtask

  task automatic sw(input logic b, input logic [7:0] a, input logic [15:0] d);
    s_wr = 1; s_byte = b; s_addr = a; s_wdata = d; edge_done();
  endtask

  task automatic hrd(input logic [5:0] a, output logic [15:0] d);
    h_addr = a; #1; d = h_rdata;
  endtask

  task automatic srd(input logic [7:0] a, output logic [15:0] d);
    s_addr = a; #1; d = s_rdata;
  endtask

  // priority in bench terms: source -> (mask bit, level), reset unmaskable
  function automatic logic [3:0] exp_level(input logic [4:0] p, input logic [3:0] m);
    logic [3:0] best = 0;
    if (p[0] && m[0]) best = 6;
    if (p[1] && m[1]) best = 8;
    if (p[2] && m[2]) best = 10;
    if (p[3] && m[3]) best = 12;
    if (p[4]) best = 14;
    return best;
  endfunction

  function automatic logic [15:0] exp_sread(input int a);
    if (a <= 1) return (16'(m_fm) << 15) | 16'h0200 | 16'(m_mask);
    if (a >= 8 && a < 16) return m_dma[(a - 8) / 2];
    if (a >= 32 && a < 48) return m_comm[(a - 32) / 2];
    return 16'h0;
  endfunction

  task automatic clear_all();
    for (int k = 0; k < 5; k++) sw(0, 8'h14 + 8'(2 * k), 16'h0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [15:0] d;
    m_fm = 0; m_mask = 0;
    for (int i = 0; i < 8; i++) m_comm[i] = 0;
    for (int i = 0; i < 4; i++) m_dma[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // reset state
    chk("R1 reset enable", 16'(adapter_en), 16'h0);
    chk("R3 reset bank", 16'(bank_sel), 16'h0);
    chk("R9 reset level", 16'(irq_level), 16'h0);

    // R1: writes ignored while disabled
    hw(0, 6'h04, 16'h0007);
    hw(1, 6'h05, 16'h0005);
    hw(0, 6'h20, 16'hBEEF);
    hw(0, 6'h00, 16'h8001);
    hw(1, 6'h03, 16'h0001);
    hw(0, 6'h08, 16'h1234);
    chk("R1 bank ignored", 16'(bank_sel), 16'h0);
    chk("R1 fm ignored", 16'(frame_mode), 16'h0);
    chk("R1 enable not set by word", 16'(adapter_en), 16'h0);
    srd(8'h20, d); chk("R1 comm ignored", d, 16'h0);
    srd(8'h08, d); chk("R1 dma ignored", d, 16'h0);
    sw(0, 8'h00, 16'h000F); m_mask = 4'hF;
    chk("R1 cmd ignored", 16'(irq_level), 16'h0);
    hw(1, 6'h01, 16'h0000);
    chk("R1 enable set by byte 1", 16'(adapter_en), 16'h1);
    hw(1, 6'h01, 16'h0000);
    chk("R1 enable stays", 16'(adapter_en), 16'h1);

    // R2: frame mode
    hw(0, 6'h00, 16'hFFFE); m_fm = 1;
    chk("R2 fm word", 16'(frame_mode), 16'h1);
    chk("R2 enable kept", 16'(adapter_en), 16'h1);
    hrd(6'h00, d); chk("R2 host read 0", d, 16'h8001);
    hw(1, 6'h00, 16'h0000); m_fm = 0;
    chk("R2 fm byte clear", 16'(frame_mode), 16'h0);
    hw(1, 6'h00, 16'h0080); m_fm = 1;
    chk("R2 fm byte set", 16'(frame_mode), 16'h1);
    hw(1, 6'h01, 16'h00FF);
    chk("R2 odd byte 1 leaves fm", 16'(frame_mode), 16'h1);

    // R3: bank sweep, both forms
    for (int v = 0; v < 16; v++) begin
      hw(1, 6'h05, 16'(v) | 16'hA0F0);
      chk("R3 bank byte", 16'(bank_sel), 16'(v % 8));
      hw(0, 6'h04, 16'(15 - v) | 16'h5500);
      chk("R3 bank word", 16'(bank_sel), 16'((15 - v) % 8));
      hrd(6'h04, d); chk("R3 bank read", d, 16'((15 - v) % 8));
    end
    hw(1, 6'h04, 16'h0006);
    chk("R3 even byte ignored", 16'(bank_sel), 16'h0);

    // R5: comm words, both directions
    for (int i = 0; i < 8; i++) begin
      m_comm[i] = 16'h1100 + 16'(i * 37);
      hw(0, 6'(32 + 2 * i), m_comm[i]);
    end
    for (int i = 0; i < 8; i++) begin
      srd(8'(32 + 2 * i), d); chk("R5 host->sub", d, m_comm[i]);
      m_comm[i] = 16'hC000 ^ 16'(i * 911);
      sw(0, 8'(32 + 2 * i), m_comm[i]);
      hrd(6'(32 + 2 * i), d); chk("R5 sub->host", d, m_comm[i]);
    end
    sw(1, 8'h21, 16'hFFFF);
    srd(8'h20, d); chk("R5 sub byte ignored", d, m_comm[0]);

    // R6: DMA words
    for (int i = 0; i < 4; i++) begin
      m_dma[i] = 16'h0D00 + 16'(i * 1031);
      hw(0, 6'(8 + 2 * i), m_dma[i]);
      sw(0, 8'(8 + 2 * i), 16'hFFFF);
      srd(8'(8 + 2 * i), d); chk("R6 dma sub read", d, m_dma[i]);
      hrd(6'(8 + 2 * i), d); chk("R6 dma host read", d, m_dma[i]);
    end

    // R7: mask load and sub view of reg 0
    for (int v = 0; v < 16; v++) begin
      if (v % 2 == 0) sw(1, 8'h01, 16'hFFF0 | 16'(v));
      else            sw(0, 8'h00, 16'hFFF0 | 16'(v));
      m_mask = 4'(v);
      srd(8'h00, d); chk("R7 sub reg0", d, exp_sread(0));
    end
    sw(1, 8'h00, 16'h0003);
    srd(8'h00, d); chk("R7 even byte no mask", d, exp_sread(0));

    // R10: full second-CPU read sweep against model
    for (int a = 0; a < 256; a++) begin
      srd(8'(a), d);
      chk((a >= 64 || (a > 1 && a < 8) || (a >= 16 && a < 32) || a >= 48) ?
          "R10 sub unmapped" : "R10 sub mapped", d, exp_sread(a));
    end
    for (int a = 16; a < 32; a += 2) begin
      hrd(6'(a), d); chk("R10 host unmapped", d, 16'h0);
    end
    hrd(6'h02, d); chk("R10 host offset 2", d, 16'h0);

    // R9/R11/R4: priority sweep over pending x mask
    for (int m = 0; m < 16; m++) begin
      for (int p = 0; p < 32; p++) begin
        sw(0, 8'h00, 16'(m)); m_mask = 4'(m);
        clear_all();
        chk("R8 all cleared", 16'(irq_level), 16'h0);
        vres_req = p[4]; vint_req = p[3]; hint_req = p[2]; pwm_req = p[0];
        edge_done();
        if (p[1]) hw(0, 6'h02, 16'h0001);
        chk("R9 level", 16'(irq_level), 16'(exp_level(5'(p), 4'(m))));
      end
    end

    // R4: bit0 clear has no effect; byte offset 3 raises
    sw(0, 8'h00, 16'h0002); clear_all();
    hw(1, 6'h03, 16'h00FE);
    chk("R4 bit0 clear no raise", 16'(irq_level), 16'h0);
    hw(1, 6'h03, 16'h0001);
    chk("R4 byte raise", 16'(irq_level), 16'h8);
    sw(1, 8'h1B, 16'h0000);
    chk("R8 odd-byte cmd clear", 16'(irq_level), 16'h0);

    // R11: each pulse alone
    sw(0, 8'h00, 16'h000F);
    clear_all(); vint_req = 1; edge_done();
    chk("R11 vint", 16'(irq_level), 16'hC);
    clear_all(); hint_req = 1; edge_done();
    chk("R11 hint", 16'(irq_level), 16'hA);
    clear_all(); pwm_req = 1; edge_done();
    chk("R11 pwm", 16'(irq_level), 16'h6);

    // R8: same-cycle raise and clear
    clear_all();
    h_wr = 1; h_byte = 1; h_addr = 6'h03; h_wdata = 16'h0001;
    s_wr = 1; s_byte = 0; s_addr = 8'h1A; s_wdata = 16'h0;
    edge_done();
    chk("R8 cmd raise beats clear", 16'(irq_level), 16'h8);
    vres_req = 1; s_wr = 1; s_byte = 0; s_addr = 8'h14; edge_done();
    chk("R8 vres pulse beats clear", 16'(irq_level), 16'hE);
    sw(0, 8'h14, 16'h0);
    chk("R8 vres cleared", 16'(irq_level), 16'h8);

    // R5: same-word collision
    h_wr = 1; h_byte = 0; h_addr = 6'h26; h_wdata = 16'hAAAA;
    s_wr = 1; s_byte = 0; s_addr = 8'h26; s_wdata = 16'h5555;
    edge_done();
    hrd(6'h26, d); chk("R5 collision host view", d, 16'h5555);
    srd(8'h26, d); chk("R5 collision sub view", d, 16'h5555);

    // R1: reset returns to disabled
    rst_n = 0; @(posedge clk); #1 rst_n = 1;
    chk("R1 reset disables", 16'(adapter_en), 16'h0);

    summary();
  end
endmodule